// File: doc/BRIEF.md
# Watchdog Frequency Recovery Controller

This block watches over the frequency setting of a programmable clock synthesizer. Software arms a down-counter after it changes the frequency. If the system hangs and software never stops the counter, the count runs out. The block then pulls the system reset line low for a fixed interval. It also drops the direct-divisor mode and forces a known frequency-select code, so that the system comes back up at a frequency that works.

The time base is a strobe, `tick_i`, whose period is a parameter. A prescaler turns these strobes into count units of nominally 250 ms. A settings port writes one field per cycle. Each field is selected by a 2-bit identifier, and the write takes effect at the next clock edge. The power-on strap code is captured while `rst` is high. When the count runs out, that strap code is the fallback, unless the safe-code select bit chooses the programmed safe code instead.

Top module: `wdog_freq_recover`

## Requirements
- R1: After reset, the enable readback is 0, the timeout flag is 0, the depth readback is 8, the select code is 5'b00010, divisor mode is 0 and the reset output is 1. The safe code resets to 5'b00010 with the safe select at 0.
- R2: A settings write with `fld_id_i`=0 and `fld_data_i[0]`=1, made while the watchdog is stopped, does four things at the next edge: it loads the count from the programmed depth, sets the enable readback to 1, clears the timeout flag and restarts the prescaler.
- R3: One count unit equals TPU ticks, where TPU = UNIT_MS*1000/TICK_US. The count drops by one on each unit. While running, the depth readback shows the remaining count. Otherwise it shows the programmed depth (`fld_id_i`=1, bits [6:0]). A depth write during a run does not change the remaining count.
- R4: On the unit that takes the count from 1 to 0, the enable readback becomes 0 and the timeout flag becomes 1.
- R5: The reset output goes low in the cycle after the expiring tick. It stays low for PULSE_UNITS count units, timed by a restarted prescaler.
- R6: On timeout, divisor mode is cleared to 0.
- R7: On timeout, the select code takes one of two values. If the safe select is 1, it takes the safe code. If the safe select is 0, it takes the strap value captured during reset, zero-extended. The safe code is bits [4:0] and the safe select is bit 5 of a write with `fld_id_i`=2.
- R8: A depth of 0, once armed, times out on the first count unit.
- R9: A write with `fld_id_i`=0 and `fld_data_i[0]`=0 stops the count with no timeout. This holds even when the write falls in the same cycle as the final unit.
- R10: A timeout overrides a software write to the select field that falls in the same cycle. That field is `fld_id_i`=3, with the code in bits [4:0] and divisor mode in bit 5.
- R11: Writing enable=1 while already running has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap sampled while high |
| tick_i | input | 1 | Time-base strobe |
| strap_i | input | 3 | Power-on strap frequency code |
| fld_wr_i | input | 1 | Settings write strobe |
| fld_id_i | input | 2 | Field identifier: 0 control, 1 depth, 2 safe, 3 select |
| fld_data_i | input | 7 | Field write data |
| wd_run_o | output | 1 | Enable readback (1 while counting) |
| wd_tmo_o | output | 1 | Timeout flag |
| wd_depth_o | output | 7 | Remaining count while running, else programmed depth |
| fsel_o | output | 5 | Frequency-select code |
| divmode_o | output | 1 | Direct-divisor mode enable |
| sys_rst_n_o | output | 1 | Active-low reset request (drive low on an open-drain pad) |

## Verification
The expiry of the count can fall in the same cycle as two kinds of software write. One is a stop write. The other is a write to the select field. The bench tracks the tick phase and the remaining count through its own model. It holds off the tick until the model shows a count of one with the prescaler on its last step. It then drives the tick together with the write. For the stop write, the check is that the enable readback, the timeout flag and the reset output all stay quiet. For the select write, the check is that the fallback code wins and divisor mode reads 0.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL  = 2'd0,
    FLD_DEPTH = 2'd1,
    FLD_SAFE  = 2'd2,
    FLD_FREQ  = 2'd3
  } fld_e;

  localparam int DEPTH_W   = 7;
  localparam int SEL_W     = 5;
  localparam int STRAP_W   = 3;
  localparam int DATA_W    = DEPTH_W;
  localparam int DEPTH_RST = 8;
  localparam int SAFE_RST  = 2;
  localparam int FSEL_RST  = 2;
endpackage

// File: rtl/wdr_prescale.sv
module wdr_prescale #(
  parameter int TPU = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic clr_i,
  output logic unit_o
);
  localparam int PW = (TPU > 1) ? $clog2(TPU) : 1;
  localparam logic [PW-1:0] LAST = PW'(TPU - 1);

  logic [PW-1:0] pc_q;

  assign unit_o = tick_i && (pc_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (tick_i) pc_q <= unit_o ? '0 : pc_q + 1'b1;
  end

  // R3
  pc_range_chk: assert property (@(posedge clk) disable iff (rst)
    pc_q <= LAST);
  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(pc_q));
endmodule

// File: rtl/wdr_counter.sv
module wdr_counter #(
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unit_i,
  input  logic          arm_req_i,
  input  logic          stop_req_i,
  input  logic [DW-1:0] depth_i,
  output logic          run_o,
  output logic          tmo_o,
  output logic [DW-1:0] cnt_o,
  output logic          arm_o,
  output logic          expire_o
);
  logic          run_q, tmo_q;
  logic [DW-1:0] cnt_q;

  assign arm_o    = arm_req_i && !run_q;
  assign expire_o = run_q && !stop_req_i && unit_i && (cnt_q <= DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      tmo_q <= 1'b0;
      cnt_q <= '0;
    end else if (arm_o) begin
      run_q <= 1'b1;
      tmo_q <= 1'b0;
      cnt_q <= depth_i;
    end else if (stop_req_i) begin
      run_q <= 1'b0;
    end else if (expire_o) begin
      run_q <= 1'b0;
      tmo_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q && unit_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign run_o = run_q;
  assign tmo_o = tmo_q;
  assign cnt_o = cnt_q;

  // R2
  arm_load_chk: assert property (@(posedge clk) disable iff (rst)
    arm_o |=> (run_q && !tmo_q && cnt_q == $past(depth_i)));
  // R4
  expire_flag_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (!run_q && tmo_q));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !unit_i && !arm_req_i && !stop_req_i) |=> $stable(cnt_q));
  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_req_i && !arm_req_i) |=> (!run_q && $stable(tmo_q)));
endmodule

// File: rtl/wdr_pulse.sv
module wdr_pulse #(
  parameter int PULSE_UNITS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic unit_i,
  input  logic expire_i,
  output logic rst_n_o
);
  localparam int PCW = (PULSE_UNITS > 1) ? $clog2(PULSE_UNITS) : 1;

  logic           low_q;
  logic [PCW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (expire_i) begin
      low_q  <= 1'b1;
      pcnt_q <= PCW'(PULSE_UNITS - 1);
    end else if (low_q && unit_i) begin
      if (pcnt_q == '0) low_q <= 1'b0;
      else              pcnt_q <= pcnt_q - 1'b1;
    end
  end

  assign rst_n_o = !low_q;

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> !rst_n_o);
  // R5
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!unit_i && !expire_i) |=> $stable(low_q));
endmodule

// File: rtl/wdr_cfg.sv
module wdr_cfg
  import wdr_pkg::*;
#(
  parameter int DW = DEPTH_W,
  parameter int SW = SEL_W,
  parameter int TW = STRAP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  fld_e          fld_i,
  input  logic [DW-1:0] data_i,
  input  logic [TW-1:0] strap_i,
  input  logic          expire_i,
  output logic [DW-1:0] depth_o,
  output logic [SW-1:0] fsel_o,
  output logic          div_o
);
  logic [DW-1:0] depth_q;
  logic [SW-1:0] safe_q, fsel_q;
  logic          ssel_q, div_q;
  logic [TW-1:0] strap_q;
  logic [SW-1:0] fallback;

  assign fallback = ssel_q ? safe_q : SW'(strap_q);

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= DW'(DEPTH_RST);
      safe_q  <= SW'(SAFE_RST);
      ssel_q  <= 1'b0;
    end else if (wr_i) begin
      if (fld_i == FLD_DEPTH) depth_q <= data_i;
      if (fld_i == FLD_SAFE) begin
        safe_q <= data_i[SW-1:0];
        ssel_q <= data_i[SW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q <= SW'(FSEL_RST);
      div_q  <= 1'b0;
    end else if (expire_i) begin
      fsel_q <= fallback;
      div_q  <= 1'b0;
    end else if (wr_i && fld_i == FLD_FREQ) begin
      fsel_q <= data_i[SW-1:0];
      div_q  <= data_i[SW];
    end
  end

  assign depth_o = depth_q;
  assign fsel_o  = fsel_q;
  assign div_o   = div_q;

  // R6
  div_clear_chk: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> !div_q);
  // R7
  safe_load_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_i && ssel_q) |=> (fsel_q == $past(safe_q)));
  // R7
  strap_load_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_i && !ssel_q) |=> (fsel_q == SW'(strap_q)));
endmodule

// File: rtl/wdog_freq_recover.sv
module wdog_freq_recover
  import wdr_pkg::*;
#(
  parameter int UNIT_MS     = 250,
  parameter int TICK_US     = 1000,
  parameter int PULSE_UNITS = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               fld_wr_i,
  input  logic [1:0]         fld_id_i,
  input  logic [DATA_W-1:0]  fld_data_i,
  output logic               wd_run_o,
  output logic               wd_tmo_o,
  output logic [DEPTH_W-1:0] wd_depth_o,
  output logic [SEL_W-1:0]   fsel_o,
  output logic               divmode_o,
  output logic               sys_rst_n_o
);
  localparam int TPU = (UNIT_MS * 1000) / TICK_US;

  fld_e               fld;
  logic               ctrl_wr, arm_req, stop_req;
  logic               unit, arm, expire, clr;
  logic               run, tmo;
  logic [DEPTH_W-1:0] cnt, depth;

  assign fld      = fld_e'(fld_id_i);
  assign ctrl_wr  = fld_wr_i && (fld == FLD_CTRL);
  assign arm_req  = ctrl_wr && fld_data_i[0];
  assign stop_req = ctrl_wr && !fld_data_i[0];
  assign clr      = arm || expire;

  generate
    if (TPU > 1) begin : g_div
      wdr_prescale #(.TPU(TPU)) i_pre (
        .clk(clk), .rst(rst), .tick_i(tick_i), .clr_i(clr), .unit_o(unit)
      );
    end else begin : g_pass
      assign unit = tick_i;
    end
  endgenerate

  wdr_counter #(.DW(DEPTH_W)) i_cnt (
    .clk(clk), .rst(rst), .unit_i(unit),
    .arm_req_i(arm_req), .stop_req_i(stop_req), .depth_i(depth),
    .run_o(run), .tmo_o(tmo), .cnt_o(cnt), .arm_o(arm), .expire_o(expire)
  );

  wdr_pulse #(.PULSE_UNITS(PULSE_UNITS)) i_pulse (
    .clk(clk), .rst(rst), .unit_i(unit), .expire_i(expire), .rst_n_o(sys_rst_n_o)
  );

  wdr_cfg #(.DW(DEPTH_W), .SW(SEL_W), .TW(STRAP_W)) i_cfg (
    .clk(clk), .rst(rst), .wr_i(fld_wr_i), .fld_i(fld), .data_i(fld_data_i),
    .strap_i(strap_i), .expire_i(expire),
    .depth_o(depth), .fsel_o(fsel_o), .div_o(divmode_o)
  );

  assign wd_run_o   = run;
  assign wd_tmo_o   = tmo;
  assign wd_depth_o = run ? cnt : depth;

  // R10
  override_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && fld_wr_i && fld == FLD_FREQ) |=> !divmode_o);
endmodule

// File: tb/test_wdog_freq_recover.sv
`timescale 1ns/1ps
module test_wdog_freq_recover;
  localparam int TPU = 4;
  localparam int PU  = 1;

  logic       clk = 1'b0;
  logic       rst;
  logic       tick_i;
  logic [2:0] strap_i;
  logic       fld_wr_i;
  logic [1:0] fld_id_i;
  logic [6:0] fld_data_i;
  logic       wd_run_o, wd_tmo_o, divmode_o, sys_rst_n_o;
  logic [6:0] wd_depth_o;
  logic [4:0] fsel_o;

  always #2.5 clk = ~clk;

  wdog_freq_recover #(.UNIT_MS(250), .TICK_US(62500), .PULSE_UNITS(PU)) i_wdog_freq_recover (
    .clk(clk), .rst(rst), .tick_i(tick_i), .strap_i(strap_i),
    .fld_wr_i(fld_wr_i), .fld_id_i(fld_id_i), .fld_data_i(fld_data_i),
    .wd_run_o(wd_run_o), .wd_tmo_o(wd_tmo_o), .wd_depth_o(wd_depth_o),
    .fsel_o(fsel_o), .divmode_o(divmode_o), .sys_rst_n_o(sys_rst_n_o)
  );

  int vectors = 0, miscomp = 0;
  int tcount = 0, tper = 3;
  bit done = 0;

  // behavioural reference state
  int m_run, m_tmo, m_cnt, m_pc, m_depth, m_safe, m_ssel, m_strap;
  int m_fsel, m_div, m_low, m_pcnt;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_tmo = 0; m_cnt = 0; m_pc = 0; m_depth = 8;
      m_safe = 2; m_ssel = 0; m_strap = int'(strap_i);
      m_fsel = 2; m_div = 0; m_low = 0; m_pcnt = 0;
    end else begin
      bit unit, arm, stop, exp_now;
      int d;
      d = int'(fld_data_i);
      unit = tick_i && (m_pc == TPU - 1);
      arm  = fld_wr_i && fld_id_i == 0 && d[0] && !m_run;
      stop = fld_wr_i && fld_id_i == 0 && !d[0];
      exp_now = m_run && !stop && unit && m_cnt <= 1;
      if (exp_now) begin
        m_div = 0; m_fsel = m_ssel ? m_safe : m_strap;
      end else if (fld_wr_i && fld_id_i == 3) begin
        m_fsel = d % 32; m_div = (d / 32) % 2;
      end
      if (exp_now) begin m_low = 1; m_pcnt = PU - 1; end
      else if (m_low && unit) begin
        if (m_pcnt == 0) m_low = 0; else m_pcnt--;
      end
      if (arm) begin m_run = 1; m_tmo = 0; m_cnt = m_depth; end
      else if (stop) m_run = 0;
      else if (exp_now) begin m_run = 0; m_tmo = 1; m_cnt = 0; end
      else if (m_run && unit) m_cnt--;
      if (arm || exp_now) m_pc = 0;
      else if (tick_i) m_pc = unit ? 0 : m_pc + 1;
      if (fld_wr_i && fld_id_i == 1) m_depth = d;
      if (fld_wr_i && fld_id_i == 2) begin m_safe = d % 32; m_ssel = (d / 32) % 2; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 enable readback", 32'(wd_run_o), 32'(m_run));
    chk("R4 timeout flag", 32'(wd_tmo_o), 32'(m_tmo));
    chk("R3 depth readback", 32'(wd_depth_o), 32'(m_run ? m_cnt : m_depth));
    chk("R7 select code", 32'(fsel_o), 32'(m_fsel));
    chk("R6 divisor mode", 32'(divmode_o), 32'(m_div));
    chk("R5 reset output", 32'(sys_rst_n_o), 32'(!m_low));
  endtask

  // drive at a negedge, let one posedge pass, compare at the next negedge
  task automatic cyc(input logic w, input logic [1:0] id, input logic [6:0] d, input logic tk);
    fld_wr_i = w; fld_id_i = id; fld_data_i = d; tick_i = tk;
    @(negedge clk);
    if (!rst) compare_all();
  endtask

  task automatic idle();
    cyc(1'b0, 2'd0, 7'd0, (tcount % tper) == 0);
    tcount++;
  endtask

  task automatic run_to_final();
    int guard = 0;
    while (!(m_run && m_cnt == 1 && m_pc == TPU - 1) && guard < 2000) begin
      idle(); guard++;
    end
  endtask

  task automatic wait_release();
    int guard = 0;
    while (!sys_rst_n_o && guard < 2000) begin idle(); guard++; end
  endtask

  initial begin
    int n;
    rst = 1; strap_i = 3'b101; fld_wr_i = 0; fld_id_i = 0; fld_data_i = 0; tick_i = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    idle();
    // R1 reset state
    chk("R1 enable", 32'(wd_run_o), 0);
    chk("R1 timeout", 32'(wd_tmo_o), 0);
    chk("R1 depth", 32'(wd_depth_o), 8);
    chk("R1 select", 32'(fsel_o), 2);
    chk("R1 divmode", 32'(divmode_o), 0);
    chk("R1 reset out", 32'(sys_rst_n_o), 1);

    // strap fallback with default depth
    cyc(1, 2'd3, 7'h2D, 0);
    cyc(1, 2'd0, 7'h01, 0);
    chk("R2 armed", 32'(wd_run_o), 1);
    chk("R2 flag cleared", 32'(wd_tmo_o), 0);
    chk("R2 count loaded", 32'(wd_depth_o), 8);
    n = 0;
    while (!wd_tmo_o && n < 400) begin idle(); n++; end
    chk("R4 expired", 32'(wd_tmo_o), 1);
    chk("R7 strap code", 32'(fsel_o), 5);
    chk("R6 divmode cleared", 32'(divmode_o), 0);
    chk("R5 reset low", 32'(sys_rst_n_o), 0);
    wait_release();

    // safe code path, redundant arm, depth write during run
    tper = 1;
    cyc(1, 2'd2, 7'h36, 0);
    cyc(1, 2'd1, 7'd3, 0);
    cyc(1, 2'd0, 7'h01, 0);
    n = 0;
    while (wd_depth_o != 2 && n < 100) begin idle(); n++; end
    cyc(1, 2'd0, 7'h01, 0);
    chk("R11 count kept", 32'(wd_depth_o), 2);
    chk("R11 still running", 32'(wd_run_o), 1);
    cyc(1, 2'd1, 7'd5, 0);
    chk("R3 remaining shown", 32'(wd_depth_o), 2);
    n = 0;
    while (!wd_tmo_o && n < 400) begin idle(); n++; end
    chk("R7 safe code", 32'(fsel_o), 22);
    wait_release();

    // zero depth
    tper = 2;
    cyc(1, 2'd1, 7'd0, 0);
    cyc(1, 2'd0, 7'h01, 0);
    n = 0;
    while (!wd_tmo_o && n < 100) begin idle(); n++; end
    chk("R8 expired", 32'(wd_tmo_o), 1);
    chk("R8 within one unit", 32'(n <= TPU * tper + 1), 1);
    wait_release();

    // stop write collides with the final unit
    cyc(1, 2'd1, 7'd2, 0);
    cyc(1, 2'd0, 7'h01, 0);
    run_to_final();
    cyc(1, 2'd0, 7'h00, 1);
    chk("R9 stopped", 32'(wd_run_o), 0);
    chk("R9 no timeout", 32'(wd_tmo_o), 0);
    chk("R9 no reset", 32'(sys_rst_n_o), 1);
    repeat (20) idle();
    chk("R9 still quiet", 32'(wd_tmo_o), 0);

    // select write collides with expiry (strap path)
    tper = 1;
    cyc(1, 2'd2, 7'h00, 0);
    cyc(1, 2'd3, 7'h3F, 0);
    cyc(1, 2'd1, 7'd1, 0);
    cyc(1, 2'd0, 7'h01, 0);
    run_to_final();
    cyc(1, 2'd3, 7'h3F, 1);
    chk("R10 divmode overridden", 32'(divmode_o), 0);
    chk("R10 select overridden", 32'(fsel_o), 5);
    wait_release();
    repeat (5) idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog expired (R4) actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end
endmodule